// File: doc/BRIEF.md
# ATA PIO Cycle Timing Sequencer

This block times the read and write strobes of programmed-I/O transfers on one ATA channel that carries two drives. A requester presents a cycle request with a drive select and a direction. Each drive has its own 4-bit timing byte. The byte holds a sample-point code, which sets how long the strobe stays low before IORDY is first looked at, and a recovery code, which sets the minimum idle time before the next strobe. The sequencer pulls the active-low read or write strobe low. It waits the coded number of clocks, then samples IORDY every clock until the drive reports ready. It releases the strobe, gives a one-clock done pulse so the data path can capture read data, and keeps busy high until the coded recovery time has passed.

Each drive also has a synchronous-DMA enable. When the addressed drive has it set, the sequencer runs no PIO cycle for that drive and answers with a one-clock reject pulse. IORDY is taken as already synchronous to `clk`. A request is taken on a rising edge where `req_valid` is high and `busy` is low. A request presented while `busy` is high is dropped and is not queued.

Top module: `pio_strobe_seq`

## Requirements
- R1: While reset is held, and after it is released with no request, `rd_n` and `wr_n` are high and `busy`, `done` and `reject` are low.
- R2: The timing byte has the sample-point code in bits [3:2]. With IORDY high, the strobe stays low for 5, 4, 3 or 2 clocks for codes 00, 01, 10 and 11. The strobe asserts on the edge that accepts the request, and IORDY is first sampled that many edges later.
- R3: The timing byte has the recovery code in bits [1:0]. Codes 00, 01, 10 and 11 give 4, 3, 2 and 1 clocks. The next strobe asserts no earlier than that many edges after the last IORDY sample. With a request always pending, the strobe is high for exactly that many clocks between cycles.
- R4: Each IORDY-low sample at or after the sample point keeps the strobe low one more clock. The edge that samples IORDY high releases the strobe, and that edge starts the recovery count.
- R5: `req_drive` = 0 takes its timing from `tim_drv0`, and `req_drive` = 1 takes its timing from `tim_drv1`.
- R6: `req_write` = 1 drives `wr_n` and `req_write` = 0 drives `rd_n`. The other strobe stays high, and the two are never low together.
- R7: `done` is high for exactly the one clock that follows strobe release.
- R8: `busy` is high from the accepting edge until one edge before the recovery time ends. A request seen while `busy` is high does not start a cycle, either then or later.
- R9: `sdma_en[d]` set for the addressed drive d makes a request give a one-clock `reject`. No strobe asserts and `busy` stays low.
- R10: The timing codes are taken at acceptance. Changing a timing byte during a cycle does not change that cycle's strobe width or recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request |
| req_drive | input | 1 | Drive select: 0 or 1 |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| tim_drv0 | input | 4 | Drive 0 timing: [3:2] sample code, [1:0] recovery code |
| tim_drv1 | input | 4 | Drive 1 timing: same layout |
| sdma_en | input | 2 | Per-drive synchronous-DMA enable, bit d for drive d |
| iordy | input | 1 | Drive ready, synchronous |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Cycle or recovery in progress |
| done | output | 1 | One-clock pulse after strobe release |
| reject | output | 1 | One-clock pulse for a request refused by the DMA enable |

## Verification
A wrong count or state in this block shows at the ports within one cycle's length. A bad sample-point count shows up as a strobe low run that is off by a clock, visible as soon as the strobe rises. A bad recovery count shows up as a wrong high gap before the next back-to-back strobe. A wrong latched code or direction shows up as the wrong strobe line or width within the first cycle after the change. A stuck state shows up as `busy` never falling, which ends the run through the watchdog.

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq #(
  parameter int CW = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_drive,
  input  logic       req_write,
  input  logic [3:0] tim_drv0,
  input  logic [3:0] tim_drv1,
  input  logic [1:0] sdma_en,
  input  logic       iordy,
  output logic       rd_n,
  output logic       wr_n,
  output logic       busy,
  output logic       done,
  output logic       reject
);

  typedef enum logic [1:0] {S_IDLE, S_STRB, S_RECV} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [1:0]   rec_q;
  logic         wr_q;

  wire [3:0] tsel     = req_drive ? tim_drv1 : tim_drv0;
  wire       refused  = sdma_en[req_drive];
  wire       strb_on  = (st == S_STRB);
  wire       at_samp  = strb_on && (cnt == '0);

  // sample clocks = 5 - code, loaded as (clocks - 1)
  wire [CW-1:0] samp_load = CW'(3'd4 - {1'b0, tsel[3:2]});
  // recovery clocks = 4 - code, loaded as (clocks - 2) when code != 11
  wire [CW-1:0] rec_load  = CW'(3'd2 - {1'b0, rec_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      rec_q  <= 2'b00;
      wr_q   <= 1'b0;
      done   <= 1'b0;
      reject <= 1'b0;
    end else begin
      done   <= 1'b0;
      reject <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            if (refused) begin
              reject <= 1'b1;
            end else begin
              st    <= S_STRB;
              cnt   <= samp_load;
              rec_q <= tsel[1:0];
              wr_q  <= req_write;
            end
          end
        end
        S_STRB: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (iordy) begin
            done <= 1'b1;
            if (rec_q == 2'b11) begin
              st <= S_IDLE;
            end else begin
              st  <= S_RECV;
              cnt <= rec_load;
            end
          end
        end
        S_RECV: begin
          if (cnt == '0) st <= S_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);
  assign rd_n = !(strb_on && !wr_q);
  assign wr_n = !(strb_on &&  wr_q);

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_hold_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_samp && !iordy) |=> (!rd_n || !wr_n));

  p_min_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n && wr_n) |=> !(rd_n && wr_n));

  p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && wr_n && $past(!rd_n || !wr_n)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_reject_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!busy && rd_n && wr_n));

endmodule

// File: tb/sim_pio_strobe_seq.sv
module sim_pio_strobe_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_drive = 1'b0, req_write = 1'b0;
  logic [3:0] tim_drv0 = 4'h0, tim_drv1 = 4'h0;
  logic [1:0] sdma_en = 2'b00;
  logic       iordy = 1'b1;
  logic       rd_n, wr_n, busy, done, reject;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  pio_strobe_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_drive(req_drive),
    .req_write(req_write), .tim_drv0(tim_drv0), .tim_drv1(tim_drv1),
    .sdma_en(sdma_en), .iordy(iordy), .rd_n(rd_n), .wr_n(wr_n),
    .busy(busy), .done(done), .reject(reject)
  );

  // {drive, write, tim0[4], tim1[4], extra_low[3], exp_width[4], exp_gap[3]}
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 1'b0, 4'b0000, 4'b1111, 3'd0, 4'd5, 3'd4},
    {1'b1, 1'b0, 4'b0000, 4'b1111, 3'd0, 4'd2, 3'd1},
    {1'b0, 1'b1, 4'b0101, 4'b0000, 3'd0, 4'd4, 3'd3},
    {1'b1, 1'b1, 4'b1111, 4'b1010, 3'd0, 4'd3, 3'd2},
    {1'b0, 1'b0, 4'b1100, 4'b0000, 3'd2, 4'd4, 3'd4},
    {1'b1, 1'b1, 4'b0000, 4'b0011, 3'd3, 4'd8, 3'd1},
    {1'b0, 1'b1, 4'b1001, 4'b0000, 3'd1, 4'd4, 3'd3},
    {1'b1, 1'b0, 4'b0000, 4'b0110, 3'd0, 4'd4, 3'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  function automatic logic strobe_low();
    return !rd_n || !wr_n;
  endfunction

  task automatic wait_idle();
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
  endtask

  initial begin
    // R1: outputs during and after reset
    repeat (3) @(negedge clk);
    chk("R1 rd_n in reset", rd_n, 1);
    chk("R1 wr_n in reset", wr_n, 1);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle outputs", {rd_n, wr_n, busy, done, reject}, 5'b11000);

    // vector table: R2 R3 R4 R5 R6 R7 R8
    foreach (VEC[v]) begin
      automatic logic       drv = VEC[v][19];
      automatic logic       wrt = VEC[v][18];
      automatic int         k   = VEC[v][9:7];
      automatic int         ew  = VEC[v][6:3];
      automatic int         eg  = VEC[v][2:0];
      automatic int         n   = ew - k;
      automatic int         width = 0, gap = 0;
      automatic logic       bad_line = 1'b0;
      tim_drv0  = VEC[v][17:14];
      tim_drv1  = VEC[v][13:10];
      req_drive = drv;
      req_write = wrt;
      iordy     = 1'b1;
      req_valid = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 40 && strobe_low(); i++) begin
        width++;
        if ((wrt ? wr_n : rd_n) != 1'b0 || (wrt ? rd_n : wr_n) != 1'b1) bad_line = 1'b1;
        iordy = (width >= n + k);
        @(negedge clk);
      end
      iordy = 1'b1;
      chk($sformatf("R2 R4 R5 width vec%0d", v), width, ew);
      chk($sformatf("R6 strobe line vec%0d", v), bad_line, 0);
      chk($sformatf("R7 done after release vec%0d", v), done, 1);
      chk($sformatf("R8 busy after release vec%0d", v), busy, (eg != 1));
      gap = 1;
      @(negedge clk);
      chk($sformatf("R7 done one clock vec%0d", v), done, 0);
      for (int i = 0; i < 20 && !strobe_low(); i++) begin
        gap++;
        @(negedge clk);
      end
      chk($sformatf("R3 recovery gap vec%0d", v), gap, eg);
      req_valid = 1'b0;
      wait_idle();
      @(negedge clk);
    end

    // R9: DMA enable on drive 1 rejects, drive 0 unaffected
    begin
      automatic int lows = 0;
      sdma_en   = 2'b10;
      req_drive = 1'b1;
      req_write = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 reject pulse", reject, 1);
      chk("R9 no busy", busy, 0);
      chk("R9 no strobe", strobe_low(), 0);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (strobe_low() || busy) lows++;
      end
      chk("R9 stays idle", lows, 0);
      chk("R9 reject cleared", reject, 0);
      tim_drv0  = 4'b1111;
      req_drive = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 other drive runs", {rd_n, reject}, 2'b00);
      wait_idle();
      sdma_en = 2'b00;
      @(negedge clk);
    end

    // R8 + R10: mid-cycle request ignored, timing latched at acceptance
    begin
      automatic int lows = 0, busies = 0;
      tim_drv0  = 4'b0000;
      req_drive = 1'b0;
      req_write = 1'b1;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      tim_drv0  = 4'b1111;
      for (int i = 0; i < 30; i++) begin
        if (!wr_n) lows++;
        if (busy) busies++;
        req_valid = (i == 2);
        @(negedge clk);
      end
      chk("R10 width latched", lows, 5);
      chk("R8 R10 busy span", busies, 8);
    end

    // R1: reset mid-cycle returns to idle
    tim_drv0  = 4'b0000;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset aborts cycle", {rd_n, wr_n, busy}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule